// File: doc/BRIEF.md
# Acquisition Trigger and Burst Controller

This block sits between a bank of sampling converters and the path that carries their samples away, and decides when samples may pass. Software programs it by sending a 16-bit control word over a byte-wide command link, low byte first. The word selects one of two capture styles. In continuous mode the block passes samples for as long as a trigger level is active. In burst mode a single trigger edge starts the capture of a fixed, power-of-two number of samples, and the end of the burst is flagged with a one-cycle done pulse. The trigger comes either from an external pin or from the control word itself. The block also drives the converters' sync line. It can hold that line high until configured, fire a single pulse when a word arrives, or pass an external sync pin straight through.

The control word fields are as follows. Bit 0 selects the mode (1 continuous, 0 burst). Bit 1 sets trigger polarity (1 active-high or rising edge, 0 active-low or falling edge). Bit 2 selects the trigger source (1 internal, 0 external pin). Bit 3 is the internal enable level used in continuous mode. Bit 4 selects the sync source (1 internal pulse, 0 external pin). Bits 11:8 hold the burst-length code. Bits 7:5 and 15:12 are reserved and must be zero. A burst holds 2^(BASE_LOG2+code) samples, so the default BASE_LOG2 of 8 gives 256 samples for code 0 and 8M samples for code 15.

The controller has four states. UNCONF is entered on reset and left only through an accepted word. IDLE means burst mode with no burst running. BURST means a burst is being counted. CONT means continuous mode. An accepted word moves any state to CONT if bit 0 is set. If bit 0 is clear, the word moves to BURST when bit 2 is set and to IDLE when it is clear. Within IDLE with the external source selected, an active edge moves the block to BURST. Within BURST, the sample strobe that completes the count moves the block to IDLE and raises done. UNCONF and CONT change only when a word is accepted.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: From reset until the first accepted control word, adc_sync is 1, capture_en is 0 and burst_done is 0.
- R2: A control word takes effect only after its second byte. A single byte on its own leaves all outputs unchanged. The new settings show at the outputs in the second cycle after the byte is sampled.
- R3: In continuous mode with the external source selected, capture_en equals the external trigger when bit 1 is 1 and its inverse when bit 1 is 0. A trigger change shows on capture_en two clock edges after it is sampled.
- R4: In continuous mode with the internal source selected, capture_en equals bit 3 of the control word, and the external trigger has no effect.
- R5: In burst mode with the internal source selected, every accepted word starts a new burst, including a word that arrives during a running burst. In that case the count restarts from zero. capture_en is 1 from the start of the burst until the burst ends.
- R6: In burst mode with the external source selected, capture_en stays 0 until an edge of the synchronised trigger arrives. That edge is rising when bit 1 is 1 and falling when bit 1 is 0. capture_en becomes 1 three clock edges after the changed trigger is first sampled.
- R7: A burst spans exactly 2^(BASE_LOG2+code) sample strobes, where code is bits 11:8.
- R8: In the cycle after the last strobe of a burst is sampled, burst_done is 1 for exactly one cycle and capture_en is 0.
- R9: A trigger edge that arrives while a burst is running is ignored and does not restart the count.
- R10: With bit 4 set, adc_sync is high for exactly one cycle after a word is accepted and low otherwise. With bit 4 clear, adc_sync follows ext_sync.
- R11: A word with any reserved bit set is discarded and leaves the state and all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte, low byte of the word first |
| ext_trig | input | 1 | External trigger pin, asynchronous |
| ext_sync | input | 1 | External active-high sync pin |
| sample_valid | input | 1 | One strobe per converter sample |
| capture_en | output | 1 | Samples are forwarded while 1 |
| adc_sync | output | 1 | Sync line to the converters, high holds them in reset |
| burst_done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
A wrong state register shows within one cycle at capture_en or adc_sync. A stuck UNCONF keeps adc_sync high, and a stray BURST raises capture_en with no trigger. A burst counter that is off by one makes capture_en fall one strobe early or late, and moves the done pulse with it. The bench catches this by counting the strobes accepted per burst against 2^(BASE_LOG2+code). A byte-framing slip or a wrongly decoded field shows as the wrong mode, polarity or length on the word after the slip. A restart on an ignored edge shows as a burst that runs longer than its programmed length.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [1:0] {
        ST_UNCONF,
        ST_IDLE,
        ST_BURST,
        ST_CONT
    } acq_state_e;

    localparam int CODE_W = 4;

    typedef struct packed {
        logic [CODE_W-1:0] len_code;
        logic              sync_int;
        logic              lvl;
        logic              src_int;
        logic              pol;
        logic              cont;
    } acq_cfg_t;

    // field placement inside the 16-bit control word
    function automatic acq_cfg_t word_to_cfg(input logic [15:0] w);
        acq_cfg_t c;
        c.cont     = w[0];
        c.pol      = w[1];
        c.src_int  = w[2];
        c.lvl      = w[3];
        c.sync_int = w[4];
        c.len_code = w[11:8];
        return c;
    endfunction

    function automatic logic word_reserved(input logic [15:0] w);
        return (|w[7:5]) | (|w[15:12]);
    endfunction

endpackage

// File: rtl/cmd_assembler.sv
module cmd_assembler #(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      byte_valid,
    input  logic [BYTE_W-1:0]         byte_in,
    output logic                      word_stb,
    output logic [BYTE_W*N_BYTES-1:0] word_out
);
    localparam int IDX_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

    logic [IDX_W-1:0]          idx_q;
    logic [BYTE_W*N_BYTES-1:0] word_q;
    logic                      stb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            word_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (byte_valid) begin
                word_q[idx_q*BYTE_W +: BYTE_W] <= byte_in;
                if (idx_q == LAST_IDX) begin
                    idx_q <= '0;
                    stb_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign word_stb = stb_q;
    assign word_out = word_q;
endmodule

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic pol,
    output logic level_act,
    output logic edge_act
);
    logic [STAGES:0] sh_q;
    logic            synced;
    logic            prev;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], trig_in};
    end

    assign synced    = sh_q[STAGES-1];
    assign prev      = sh_q[STAGES];
    assign level_act = pol ? synced : ~synced;
    assign edge_act  = pol ? (synced & ~prev) : (~synced & prev);
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
    parameter int BASE_LOG2 = 8,
    parameter int CODE_W    = 4,
    parameter int CNT_W     = BASE_LOG2 + (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [CODE_W-1:0] code,
    output logic              last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] span;

    // span = burst length minus one, as a mask of ones
    assign span = ~({CNT_W{1'b1}} << (BASE_LOG2 + int'(code)));

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (step)  cnt_q <= cnt_q + 1'b1;
    end

    assign last = step & (cnt_q == span);
endmodule

// File: rtl/acq_trigger_ctrl.sv
module acq_trigger_ctrl #(
    parameter int BASE_LOG2  = 8,
    parameter int SYNC_STAGE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       ext_trig,
    input  logic       ext_sync,
    input  logic       sample_valid,
    output logic       capture_en,
    output logic       adc_sync,
    output logic       burst_done
);
    import acq_pkg::*;

    localparam int BYTE_W  = 8;
    localparam int N_BYTES = 2;
    localparam int CNT_W   = BASE_LOG2 + (1 << CODE_W) - 1;

    logic                      word_stb;
    logic [BYTE_W*N_BYTES-1:0] word;
    logic                      word_ok;
    acq_cfg_t                  new_cfg;
    acq_cfg_t                  cfg_q;
    acq_state_e                state_q, state_d;
    logic                      level_act, edge_act;
    logic                      cnt_clear, cnt_step, cnt_last;
    logic                      done_q, done_d;
    logic                      sync_pulse_q;

    cmd_assembler #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_cmd (
        .clk(clk), .rst_n(rst_n), .byte_valid(cmd_valid), .byte_in(cmd_byte),
        .word_stb(word_stb), .word_out(word)
    );

    trig_sync #(.STAGES(SYNC_STAGE)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_in(ext_trig), .pol(cfg_q.pol),
        .level_act(level_act), .edge_act(edge_act)
    );

    burst_counter #(.BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .step(cnt_step),
        .code(cfg_q.len_code), .last(cnt_last)
    );

    assign new_cfg  = word_to_cfg(word);
    assign word_ok  = word_stb & ~word_reserved(word);
    assign cnt_step = sample_valid & (state_q == ST_BURST);

    // next-state logic
    always_comb begin
        state_d   = state_q;
        cnt_clear = 1'b0;
        done_d    = 1'b0;
        if (word_ok) begin
            cnt_clear = 1'b1;
            if (new_cfg.cont)         state_d = ST_CONT;
            else if (new_cfg.src_int) state_d = ST_BURST;
            else                      state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_UNCONF: state_d = ST_UNCONF;
                ST_CONT:   state_d = ST_CONT;
                ST_IDLE: begin
                    if (!cfg_q.src_int && edge_act) begin
                        state_d   = ST_BURST;
                        cnt_clear = 1'b1;
                    end
                end
                ST_BURST: begin
                    if (cnt_last) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_UNCONF;
            cfg_q        <= '0;
            done_q       <= 1'b0;
            sync_pulse_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            done_q       <= done_d;
            sync_pulse_q <= word_ok & new_cfg.sync_int;
            if (word_ok) cfg_q <= new_cfg;
        end
    end

    // outputs
    always_comb begin
        capture_en = 1'b0;
        adc_sync   = cfg_q.sync_int ? sync_pulse_q : ext_sync;
        unique case (state_q)
            ST_UNCONF: adc_sync   = 1'b1;
            ST_IDLE:   capture_en = 1'b0;
            ST_BURST:  capture_en = 1'b1;
            ST_CONT:   capture_en = cfg_q.src_int ? cfg_q.lvl : level_act;
        endcase
        burst_done = done_q;
    end
endmodule

// File: rtl/acq_trigger_chk.sv
module acq_trigger_chk (
    input logic                clk,
    input logic                rst_n,
    input acq_pkg::acq_state_e state,
    input logic                word_ok,
    input logic                sync_int,
    input logic                sample_valid,
    input logic                capture_en,
    input logic                adc_sync,
    input logic                burst_done
);
    import acq_pkg::*;

    a_r1_unconf_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNCONF) |-> (adc_sync && !capture_en && !burst_done));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);

    a_r8_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> !capture_en);

    a_r5_burst_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !sample_valid && !word_ok) |=> capture_en);

    a_r10_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_UNCONF && sync_int && adc_sync && !word_ok) |=> !adc_sync);
endmodule

bind acq_trigger_ctrl acq_trigger_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .word_ok(word_ok),
    .sync_int(cfg_q.sync_int), .sample_valid(sample_valid),
    .capture_en(capture_en), .adc_sync(adc_sync), .burst_done(burst_done)
);

// File: tb/sim_acq_trigger_ctrl.sv
`timescale 1ns/1ps
module sim_acq_trigger_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       ext_trig = 1'b0;
    logic       ext_sync = 1'b0;
    logic       sample_valid = 1'b0;
    logic       capture_en, adc_sync, burst_done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    acq_trigger_ctrl #(.BASE_LOG2(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .ext_trig(ext_trig), .ext_sync(ext_sync), .sample_valid(sample_valid),
        .capture_en(capture_en), .adc_sync(adc_sync), .burst_done(burst_done)
    );

    // {pol, trig, expected capture_en}
    localparam logic [2:0] CONT_TAB [8] = '{
        3'b100, 3'b111, 3'b100, 3'b111,
        3'b010, 3'b001, 3'b010, 3'b001
    };

    function automatic logic [15:0] mk(input logic cont, pol, src, lvl, syn,
                                       input logic [3:0] code);
        return {4'h0, code, 3'b000, syn, lvl, src, pol, cont};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        cmd_valid = 1'b1;
        cmd_byte  = w[7:0];
        @(negedge clk);
        cmd_byte  = w[15:8];
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe();
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_burst(output int n, output int dn, output int extra);
        n = 0; dn = 0; extra = 0;
        while (capture_en && n < 100) begin
            sample_valid = 1'b1;
            @(negedge clk);
            sample_valid = 1'b0;
            n++;
            if (burst_done) dn++;
            @(negedge clk);
            if (burst_done) extra++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n, dn, ex;
        logic cur_pol;
        repeat (3) @(negedge clk);
        // R1 reset / unconfigured
        chk("R1 sync", int'(adc_sync), 1);
        chk("R1 cap", int'(capture_en), 0);
        chk("R1 done", int'(burst_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 sync after reset", int'(adc_sync), 1);

        // R2 single byte has no effect (cont, internal, lvl=1)
        send_byte(8'h0D);
        repeat (4) @(negedge clk);
        chk("R2 half word cap", int'(capture_en), 0);
        chk("R2 half word sync", int'(adc_sync), 1);
        send_byte(8'h00);
        @(negedge clk);
        chk("R2 completed word", int'(capture_en), 1);
        chk("R4 internal level 1", int'(capture_en), 1);
        // R10 external pass-through
        chk("R10 ext sync low", int'(adc_sync), 0);
        ext_sync = 1'b1; #1;
        chk("R10 ext sync high", int'(adc_sync), 1);
        ext_sync = 1'b0; #1;
        chk("R10 ext sync low again", int'(adc_sync), 0);

        // R4 internal level 0 ignores external trigger
        send_word(mk(1, 1, 1, 0, 0, 0));
        ext_trig = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 internal level 0 with trig", int'(capture_en), 0);
        ext_trig = 1'b0;
        repeat (3) @(negedge clk);

        // R3 continuous external level table
        cur_pol = 1'b1;
        send_word(mk(1, 1, 0, 0, 0, 0));
        for (int i = 0; i < 8; i++) begin
            if (CONT_TAB[i][2] != cur_pol) begin
                cur_pol = CONT_TAB[i][2];
                send_word(mk(1, cur_pol, 0, 0, 0, 0));
            end
            ext_trig = CONT_TAB[i][1];
            repeat (2) @(negedge clk);
            chk($sformatf("R3 vector %0d", i), int'(capture_en), int'(CONT_TAB[i][0]));
        end
        ext_trig = 1'b0;

        // R11 reserved bits discard the word
        send_word(mk(1, 1, 1, 1, 0, 0));
        chk("R11 setup", int'(capture_en), 1);
        send_word(16'h0040 | mk(0, 1, 1, 0, 1, 0));
        repeat (2) @(negedge clk);
        chk("R11 reserved low byte cap", int'(capture_en), 1);
        send_word(16'h2000 | mk(0, 1, 1, 0, 1, 0));
        chk("R11 reserved high byte sync", int'(adc_sync), 0);
        repeat (2) @(negedge clk);
        chk("R11 reserved high byte cap", int'(capture_en), 1);

        // R10 internal sync pulse
        send_word(mk(1, 1, 1, 1, 1, 0));
        chk("R10 pulse high", int'(adc_sync), 1);
        @(negedge clk);
        chk("R10 pulse ends", int'(adc_sync), 0);
        ext_sync = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 ext ignored when internal", int'(adc_sync), 0);
        ext_sync = 1'b0;

        // R5 R7 R8 internal burst, code 0 -> 4
        send_word(mk(0, 1, 1, 0, 0, 0));
        chk("R5 burst starts", int'(capture_en), 1);
        run_burst(n, dn, ex);
        chk("R7 len code0", n, 4);
        chk("R8 done once", dn, 1);
        chk("R8 done one cycle", ex, 0);
        // code 3 -> 32
        send_word(mk(0, 1, 1, 0, 0, 3));
        run_burst(n, dn, ex);
        chk("R7 len code3", n, 32);
        chk("R8 done code3", dn, 1);
        // R5 restart mid-burst
        send_word(mk(0, 1, 1, 0, 0, 0));
        strobe(); strobe();
        send_word(mk(0, 1, 1, 0, 0, 0));
        run_burst(n, dn, ex);
        chk("R5 restart count", n, 4);

        // R6 external rising, code 1 -> 8, with R9 ignored edge
        ext_trig = 1'b0;
        send_word(mk(0, 1, 0, 0, 0, 1));
        repeat (3) @(negedge clk);
        chk("R6 idle waits", int'(capture_en), 0);
        ext_trig = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 not yet", int'(capture_en), 0);
        @(negedge clk);
        chk("R6 rising start", int'(capture_en), 1);
        strobe(); strobe();
        ext_trig = 1'b0;
        repeat (3) @(negedge clk);
        ext_trig = 1'b1;
        repeat (3) @(negedge clk);
        run_burst(n, dn, ex);
        chk("R9 edge ignored remaining", n, 6);
        repeat (5) @(negedge clk);
        chk("R8 stays idle", int'(capture_en), 0);

        // R6 external falling, code 0 -> 4
        send_word(mk(0, 0, 0, 0, 0, 0));
        repeat (4) @(negedge clk);
        chk("R6 falling idle", int'(capture_en), 0);
        ext_trig = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 falling start", int'(capture_en), 1);
        run_burst(n, dn, ex);
        chk("R7 falling len", n, 4);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule